// File: doc/BRIEF.md
# Cartridge Disk Controller Register Interface

This block is the bus-slave face of a four-drive cartridge disk controller. A host reaches five 16-bit registers through word or byte accesses: control/status, bus address, disk address, a multipurpose register and a bus address extension. The block keeps the derived bits of the control/status register coherent. The error summary follows the individual error bits. The drive-ready bit follows the busy line of the selected drive. The two memory-extension bits are one store, seen through both the control/status and the extension register.

Writing control/status with the done bit clear issues a command. The function code and drive number leave the block with a one-cycle start pulse. The no-op code instead completes at once. An engine outside the block reports completion through a done strobe carrying error bits. It can also refill the three-entry multipurpose queue, which software drains one entry per read. Seek arithmetic, data movement and media storage sit outside this block.

Top module: `dkc_reg_if`

## Requirements
- R1: Address bits 3:1 select the register: 0 control/status, 1 bus address, 2 disk address, 3 multipurpose, 4 extension. Bus address bit 0 always reads 0. The extension register keeps 6 bits, and its bits 15:6 read 0.
- R2: When `bus_byte` is 1, the byte in `bus_wdata[7:0]` replaces the high byte of the register if address bit 0 is 1, and the low byte if it is 0. A byte write to the odd extension address changes nothing.
- R3: A control/status write stores only bits 9:1: function 3:1, extension mirror 5:4, interrupt enable 6, done 7, drive 9:8. The bits written at 5:4 land in extension bits 1:0. Extension bits 1:0 read back at control/status bits 5:4.
- R4: Control/status bits 14:10 are error flags, and bit 15 reads 1 exactly when any of them is set. Bit 0 reads 0 while `drv_busy` of the selected drive is 1, and 1 otherwise.
- R5: A read of the multipurpose register returns entry 0. The same access moves entry 1 into entry 0 and entry 2 into entry 1, and entry 2 is kept. A bus write loads the merged value into all three entries. `res_load` loads `res_words` (entry 0 in the low 16 bits).
- R6: A control/status write with bit 7 set starts nothing. It drops `irq` if the written enable bit is 0. It raises `irq` if done was already 1 and the written enable bit is 1.
- R7: A control/status write with bit 7 clear clears `irq` and bits 15:10. For a nonzero function it gives `cmd_start` for exactly the one cycle after the write, with `cmd_func` and `cmd_drive` holding the written values, and done stays 0. Function 0 instead sets done at once, sets `irq` to the written enable bit, and gives no start pulse.
- R8: `cmd_done` ORs `cmd_err` into control/status bits 14:10 and sets done. It sets `irq` to the interrupt enable bit.
- R9: After reset, control/status holds only done (reads 0x0081 when the drive is idle). All other registers and queue entries read 0, `irq` is 0, and `drv_stat_clr` is 1 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte access when 1 |
| bus_addr | input | 4 | Byte address within the block |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Read data for the addressed register |
| drv_busy | input | 4 | Per-drive busy indication |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_func | output | 3 | Function code of the command |
| cmd_drive | output | 2 | Drive number of the command |
| cmd_done | input | 1 | Completion strobe from the engine |
| cmd_err | input | 5 | Error flags for bits 14:10 on completion |
| res_load | input | 1 | Load the multipurpose queue from the engine |
| res_words | input | 48 | Three queue words, entry 0 lowest |
| irq | output | 1 | Interrupt request |
| drv_stat_clr | output | 1 | Clears latched drive status during reset |

## Verification
Read data is combinational, so the bench samples `bus_rdata` one nanosecond after it drives a read, inside the same cycle. The queue pop that the read causes takes effect at the following edge. Write effects, start pulses and the `irq` changes caused by writes or completion strobes appear after the one capturing edge. The bench samples them at the falling edge that follows. It then checks one falling edge later that `cmd_start` has gone low again. Each scenario task drives its stimulus at a falling edge and never samples at a rising edge.

// File: rtl/dkc_pkg.sv
// Shared constants and helpers for the disk controller register interface.
// Assumes a 16-bit register width and three-bit register offsets.
package dkc_pkg;
    localparam int DW = 16;
    localparam int OFF_W = 3;
    localparam int ERR_W = 5;

    typedef enum logic [OFF_W-1:0] {
        OFF_CSR = 3'd0,
        OFF_BA  = 3'd1,
        OFF_DA  = 3'd2,
        OFF_MP  = 3'd3,
        OFF_EXT = 3'd4
    } reg_off_e;

    localparam logic [2:0] FUNC_NOP = 3'd0;

    // Merge a bus write into a current register value by byte lane.
    function automatic logic [DW-1:0] lane_merge(
        input logic [DW-1:0] cur,
        input logic [DW-1:0] wd,
        input logic          byte_acc,
        input logic          hi_lane
    );
        if (!byte_acc)
            lane_merge = wd;
        else if (hi_lane)
            lane_merge = {wd[7:0], cur[7:0]};
        else
            lane_merge = {cur[15:8], wd[7:0]};
    endfunction
endpackage

// File: rtl/dkc_addr_regs.sv
// Bus address and disk address registers.
// Assumes the caller has already merged byte lanes; bus address bit 0 is not stored.
module dkc_addr_regs
    import dkc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ba_we,
    input  logic [DW-1:0] ba_wd,
    input  logic          da_we,
    input  logic [DW-1:0] da_wd,
    output logic [DW-1:0] ba_rd,
    output logic [DW-1:0] da_rd
);
    logic [DW-1:1] ba_q;
    logic [DW-1:0] da_q;

    // Capture bus address writes, dropping bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     ba_q <= '0;
        else if (ba_we) ba_q <= ba_wd[DW-1:1];
    end

    // Capture disk address writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     da_q <= '0;
        else if (da_we) da_q <= da_wd;
    end

    assign ba_rd = {ba_q, 1'b0};
    assign da_rd = da_q;
endmodule

// File: rtl/dkc_mp_queue.sv
// Multipurpose register queue: reads pop toward entry 0, bus writes fill
// every entry, and the engine can load all entries at once.
// Assumes bus write wins over engine load, which wins over a pop.
module dkc_mp_queue
    import dkc_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_all,
    input  logic [DW-1:0]       wr_data,
    input  logic                ld,
    input  logic [DEPTH*DW-1:0] ld_words,
    input  logic                pop,
    output logic [DW-1:0]       head
);
    logic [DW-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] shift_in;
        if (i == DEPTH - 1) begin : g_last
            assign shift_in = ent_q[i];
        end else begin : g_mid
            assign shift_in = ent_q[i+1];
        end

        // Update one queue entry by priority of write, load, pop.
        always_ff @(posedge clk) begin
            if (!rst_n)      ent_q[i] <= '0;
            else if (wr_all) ent_q[i] <= wr_data;
            else if (ld)     ent_q[i] <= ld_words[i*DW +: DW];
            else if (pop)    ent_q[i] <= shift_in;
        end
    end

    assign head = ent_q[0];
endmodule

// File: rtl/dkc_csr.sv
// Control/status and extension registers with command issue and interrupt.
// Assumes csr_wd is already byte-merged; the extension low bits are the single
// store behind control/status bits 5:4. A completion strobe is applied after
// any bus write in the same cycle.
module dkc_csr
    import dkc_pkg::*;
#(
    parameter int N_DRV = 4,
    parameter int EXT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csr_we,
    input  logic [DW-1:0]            csr_wd,
    input  logic                     ext_we,
    input  logic [EXT_W-1:0]         ext_wd,
    input  logic [N_DRV-1:0]         drv_busy,
    input  logic                     done_stb,
    input  logic [ERR_W-1:0]         done_err,
    output logic [DW-1:0]            csr_rd,
    output logic [DW-1:0]            ext_rd,
    output logic                     irq,
    output logic                     start,
    output logic [2:0]               func,
    output logic [$clog2(N_DRV)-1:0] drive,
    output logic                     ie
);
    localparam int DRV_W = $clog2(N_DRV);

    logic [2:0]       func_q, func_n;
    logic [DRV_W-1:0] drv_q, drv_n;
    logic             ie_q, ie_n;
    logic             done_q, done_n;
    logic [ERR_W-1:0] err_q, err_n;
    logic [EXT_W-1:0] ext_q, ext_n;
    logic             irq_q, irq_n;
    logic             start_n;

    // Next-state of all control fields from bus write then completion.
    always_comb begin
        func_n  = func_q;
        drv_n   = drv_q;
        ie_n    = ie_q;
        done_n  = done_q;
        err_n   = err_q;
        ext_n   = ext_q;
        irq_n   = irq_q;
        start_n = 1'b0;
        if (csr_we) begin
            func_n     = csr_wd[3:1];
            ext_n[1:0] = csr_wd[5:4];
            ie_n       = csr_wd[6];
            done_n     = csr_wd[7];
            drv_n      = csr_wd[9:8];
            if (csr_wd[7]) begin
                if (!csr_wd[6])  irq_n = 1'b0;
                else if (done_q) irq_n = 1'b1;
            end else begin
                err_n = '0;
                irq_n = 1'b0;
                if (csr_wd[3:1] == FUNC_NOP) begin
                    done_n = 1'b1;
                    irq_n  = csr_wd[6];
                end else begin
                    start_n = 1'b1;
                end
            end
        end else if (ext_we) begin
            ext_n = ext_wd;
        end
        if (done_stb) begin
            err_n  = err_n | done_err;
            done_n = 1'b1;
            irq_n  = ie_n;
        end
    end

    // Register the control fields; reset leaves only done set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
            drv_q  <= '0;
            ie_q   <= 1'b0;
            done_q <= 1'b1;
            err_q  <= '0;
            ext_q  <= '0;
            irq_q  <= 1'b0;
            start  <= 1'b0;
        end else begin
            func_q <= func_n;
            drv_q  <= drv_n;
            ie_q   <= ie_n;
            done_q <= done_n;
            err_q  <= err_n;
            ext_q  <= ext_n;
            irq_q  <= irq_n;
            start  <= start_n;
        end
    end

    assign csr_rd = {|err_q, err_q, drv_q, done_q, ie_q, ext_q[1:0], func_q,
                     ~drv_busy[drv_q]};
    assign ext_rd = {{(DW-EXT_W){1'b0}}, ext_q};
    assign irq    = irq_q;
    assign func   = func_q;
    assign drive  = drv_q;
    assign ie     = ie_q;
endmodule

// File: rtl/dkc_reg_if.sv
// Top of the disk controller register interface: decodes bus accesses,
// merges byte lanes and muxes read data from the register sub-blocks.
// Assumes single-cycle accesses; read side effects occur at the clock edge.
module dkc_reg_if
    import dkc_pkg::*;
#(
    parameter int N_DRV     = 4,
    parameter int MPQ_DEPTH = 3,
    parameter int EXT_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic                       bus_byte,
    input  logic [OFF_W:0]             bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    output logic [DW-1:0]              bus_rdata,
    input  logic [N_DRV-1:0]           drv_busy,
    output logic                       cmd_start,
    output logic [2:0]                 cmd_func,
    output logic [$clog2(N_DRV)-1:0]   cmd_drive,
    input  logic                       cmd_done,
    input  logic [ERR_W-1:0]           cmd_err,
    input  logic                       res_load,
    input  logic [MPQ_DEPTH*DW-1:0]    res_words,
    output logic                       irq,
    output logic                       drv_stat_clr
);
    reg_off_e      off;
    logic          hi_lane, is_wr, is_rd;
    logic [DW-1:0] csr_rd, ext_rd, ba_rd, da_rd, mp_head;
    logic          csr_ie;

    assign off     = reg_off_e'(bus_addr[OFF_W:1]);
    assign hi_lane = bus_addr[0];
    assign is_wr   = bus_sel & bus_wr;
    assign is_rd   = bus_sel & ~bus_wr;

    dkc_csr #(.N_DRV(N_DRV), .EXT_W(EXT_W)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_we   (is_wr && off == OFF_CSR),
        .csr_wd   (lane_merge(csr_rd, bus_wdata, bus_byte, hi_lane)),
        .ext_we   (is_wr && off == OFF_EXT && !(bus_byte && hi_lane)),
        .ext_wd   (bus_wdata[EXT_W-1:0]),
        .drv_busy (drv_busy),
        .done_stb (cmd_done),
        .done_err (cmd_err),
        .csr_rd   (csr_rd),
        .ext_rd   (ext_rd),
        .irq      (irq),
        .start    (cmd_start),
        .func     (cmd_func),
        .drive    (cmd_drive),
        .ie       (csr_ie)
    );

    dkc_addr_regs u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .ba_we (is_wr && off == OFF_BA),
        .ba_wd (lane_merge(ba_rd, bus_wdata, bus_byte, hi_lane)),
        .da_we (is_wr && off == OFF_DA),
        .da_wd (lane_merge(da_rd, bus_wdata, bus_byte, hi_lane)),
        .ba_rd (ba_rd),
        .da_rd (da_rd)
    );

    dkc_mp_queue #(.DEPTH(MPQ_DEPTH)) u_mpq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_all   (is_wr && off == OFF_MP),
        .wr_data  (lane_merge(mp_head, bus_wdata, bus_byte, hi_lane)),
        .ld       (res_load),
        .ld_words (res_words),
        .pop      (is_rd && off == OFF_MP),
        .head     (mp_head)
    );

    // Select read data for the addressed register.
    always_comb begin
        unique case (off)
            OFF_CSR: bus_rdata = csr_rd;
            OFF_BA:  bus_rdata = ba_rd;
            OFF_DA:  bus_rdata = da_rd;
            OFF_MP:  bus_rdata = mp_head;
            OFF_EXT: bus_rdata = ext_rd;
            default: bus_rdata = '0;
        endcase
    end

    assign drv_stat_clr = ~rst_n;
endmodule

// File: rtl/dkc_reg_if_chk.sv
// Property checker for the register interface, bound to the top module.
module dkc_reg_if_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic        bus_byte,
    input logic [3:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        cmd_start,
    input logic        cmd_done,
    input logic        irq,
    input logic        ie
);
    // R4: summary bit agrees with the individual error flags on a read.
    a_r4_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[3:1] == 3'd0)
        |-> bus_rdata[15] == (|bus_rdata[14:10]));

    // R1: bus address bit 0 never reads as 1.
    a_r1_ba_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[3:1] == 3'd1) |-> !bus_rdata[0]);

    // R1: extension register upper bits read 0.
    a_r1_ext_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[3:1] == 3'd4) |-> bus_rdata[15:6] == 10'd0);

    // R7: a start pulse only follows a control/status write.
    a_r7_start_source: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(bus_sel && bus_wr && bus_addr[3:1] == 3'd0));

    // R6: done-set word write with enable 0 drops the request.
    a_r6_ie_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_byte && bus_addr[3:1] == 3'd0
         && bus_wdata[7] && !bus_wdata[6] && !cmd_done) |=> !irq);

    // R8: a completion leaves the request equal to interrupt enable.
    a_r8_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !(bus_sel && bus_wr)) |=> irq == ie);
endmodule

bind dkc_reg_if dkc_reg_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmd_start (cmd_start),
    .cmd_done  (cmd_done),
    .irq       (irq),
    .ie        (csr_ie)
);

// File: tb/dkc_reg_if_bench.sv
`timescale 1ns/1ps
module dkc_reg_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  drv_busy = '0;
    logic        cmd_start;
    logic [2:0]  cmd_func;
    logic [1:0]  cmd_drive;
    logic        cmd_done = 1'b0;
    logic [4:0]  cmd_err = '0;
    logic        res_load = 1'b0;
    logic [47:0] res_words = '0;
    logic        irq, drv_stat_clr;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    dkc_reg_if u_dkc_reg_if (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_byte = b; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_byte = 0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic complete(input logic [4:0] e);
        @(negedge clk);
        cmd_done = 1; cmd_err = e;
        @(negedge clk);
        cmd_done = 0; cmd_err = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        chk("R9 stat_clr in reset", {15'd0, drv_stat_clr}, 16'd1);
        rst_n = 1;
        @(negedge clk);
        chk("R9 stat_clr released", {15'd0, drv_stat_clr}, 16'd0);
        chk("R9 irq", {15'd0, irq}, 16'd0);
        brd(4'd0, d); chk("R9 csr", d, 16'h0081);
        brd(4'd2, d); chk("R9 ba", d, 16'h0000);
        brd(4'd4, d); chk("R9 da", d, 16'h0000);
        brd(4'd8, d); chk("R9 ext", d, 16'h0000);
    endtask

    task automatic t_addr_regs();
        logic [15:0] d;
        bwr(4'd2, 16'hFFFF, 0); brd(4'd2, d); chk("R1 ba bit0", d, 16'hFFFE);
        bwr(4'd4, 16'h1234, 0); brd(4'd4, d); chk("R1 da", d, 16'h1234);
        bwr(4'd8, 16'hFFFF, 0); brd(4'd8, d); chk("R1 ext width", d, 16'h003F);
        brd(4'd0, d); chk("R3 ext mirror in csr", d & 16'h0030, 16'h0030);
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        bwr(4'd5, 16'h00AB, 1); brd(4'd4, d); chk("R2 odd lane", d, 16'hAB34);
        bwr(4'd4, 16'h00CD, 1); brd(4'd4, d); chk("R2 even lane", d, 16'hABCD);
        bwr(4'd9, 16'h0015, 1); brd(4'd8, d); chk("R2 odd ext ignored", d, 16'h003F);
    endtask

    task automatic t_csr_mask();
        logic [15:0] d;
        bwr(4'd0, 16'hFFFF, 0);
        chk("R6 no start", {15'd0, cmd_start}, 16'd0);
        chk("R6 irq raised", {15'd0, irq}, 16'd1);
        brd(4'd0, d); chk("R3 csr mask", d, 16'h03FF);
        bwr(4'd0, 16'h0080, 0);
        chk("R6 irq dropped", {15'd0, irq}, 16'd0);
        brd(4'd8, d); chk("R3 csr writes ext", d, 16'h003C);
    endtask

    task automatic t_ready();
        logic [15:0] d;
        bwr(4'd0, 16'h0280, 0);
        drv_busy = 4'b0100;
        brd(4'd0, d); chk("R4 busy drive", d, 16'h0280);
        drv_busy = 4'b1011;
        brd(4'd0, d); chk("R4 idle drive", d, 16'h0281);
        drv_busy = 4'b0000;
    endtask

    task automatic t_command();
        logic [15:0] d;
        bwr(4'd0, 16'h014C, 0);
        chk("R7 start", {15'd0, cmd_start}, 16'd1);
        chk("R7 func", {13'd0, cmd_func}, 16'd6);
        chk("R7 drive", {14'd0, cmd_drive}, 16'd1);
        @(negedge clk);
        chk("R7 start single", {15'd0, cmd_start}, 16'd0);
        brd(4'd0, d); chk("R7 done clear", d, 16'h014D);
        complete(5'b00101);
        chk("R8 irq with ie", {15'd0, irq}, 16'd1);
        brd(4'd0, d); chk("R8 errors and summary", d, 16'h95CD);
        bwr(4'd0, 16'h0180, 0);
        chk("R6 ie off drops", {15'd0, irq}, 16'd0);
        brd(4'd0, d); chk("R6 errors kept", d, 16'h9581);
        bwr(4'd0, 16'h0140, 0);
        chk("R7 nop no start", {15'd0, cmd_start}, 16'd0);
        chk("R7 nop irq", {15'd0, irq}, 16'd1);
        brd(4'd0, d); chk("R7 nop clears errors", d, 16'h01C1);
        bwr(4'd0, 16'h0006, 0);
        chk("R7 start seek", {15'd0, cmd_start}, 16'd1);
        chk("R7 irq cleared", {15'd0, irq}, 16'd0);
        complete(5'b00000);
        chk("R8 irq without ie", {15'd0, irq}, 16'd0);
        brd(4'd0, d); chk("R8 done set", d, 16'h0087);
    endtask

    task automatic t_mp();
        logic [15:0] d;
        bwr(4'd6, 16'h1111, 0);
        bwr(4'd7, 16'h0022, 1);
        for (int i = 0; i < 3; i++) begin
            brd(4'd6, d); chk("R5 write fills all", d, 16'h2211);
        end
        @(negedge clk);
        res_load = 1; res_words = {16'hCCCC, 16'hBBBB, 16'hAAAA};
        @(negedge clk);
        res_load = 0;
        brd(4'd6, d); chk("R5 pop 0", d, 16'hAAAA);
        brd(4'd6, d); chk("R5 pop 1", d, 16'hBBBB);
        brd(4'd6, d); chk("R5 pop 2", d, 16'hCCCC);
        brd(4'd6, d); chk("R5 last kept", d, 16'hCCCC);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_addr_regs();
        t_bytes();
        t_csr_mask();
        t_ready();
        t_command();
        t_mp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule